// File: doc/BRIEF.md
# Dual Converter Sequence Coordinator

This block drives two conversion sequencers, a primary and a secondary, each connected to its own abstract converter through a start pulse, a channel number, a done strobe and a 16-bit result. Each sequencer walks through a programmable list of channel numbers. It converts one entry at a time and keeps the most recent result.

In independent mode the two sequencers run on their own start sources and do not affect each other. In parallel mode a single external trigger, picked by a select field, starts both lists at once, and they then advance slot by slot in lockstep. Each completed slot yields one 32-bit word made of both results, offered to a DMA-style consumer through a valid/ready handshake. When both converters would sample the same channel in a slot, the secondary's start is held back until the primary has finished that conversion. A sticky end-of-sequence flag reports completion.

Top module: `dual_conv_sync`

## Requirements
- R1: In independent mode (mode_o = 0) the primary starts on the selected external trigger or on `m_sw_start_i`, and the secondary starts only on `s_sw_start_i`. The two lists may run at the same time without changing each other's channel order.
- R2: The 3-bit `trig_sel_i` selects bit `trig_sel_i` of `ext_trig_i` as the external trigger. A pulse on any other bit starts nothing.
- R3: A list of length field L converts entries 0..L in order. Entry k is taken from bits [4k+3:4k] of the channel vector. Each entry gets exactly one start pulse, and the next entry is issued only after the current done.
- R4: In parallel mode (mode_o = 1) the selected trigger starts both lists, and both use the primary's length field. Neither side begins slot k+1 before both have finished slot k. Both software starts are ignored.
- R5: In parallel mode, when both lists hold the same channel in a slot, the secondary's start waits until the primary's done. The two converters never work on the same channel at once.
- R6: In parallel mode `pk_valid_o` rises once both results of a slot are in, with `pk_data_o` = {secondary result, primary result}. Valid and data hold until `pk_ready_i` is seen.
- R7: A new word arriving while the previous one is still untaken replaces it and sets the sticky `ovr_o`, which `ovr_clr_i` clears.
- R8: In parallel mode `eoc_o` is set only when the last slot of both lists is done, and only if `ie_m_i` or `ie_s_i` is 1.
- R9: In independent mode the end of the primary list sets `eoc_o` if `ie_m_i` is 1, and the end of the secondary list sets it if `ie_s_i` is 1.
- R10: `eoc_o` stays set until a cycle with `eoc_clr_i` = 1. A new setting event in that same cycle wins.
- R11: A `mode_wr_i` pulse loads `mode_req_i` into `mode_o` only while both sequencers are idle. A pulse while either is busy is ignored.
- R12: After reset the mode is independent, no start is issued, and `pk_valid_o`, `ovr_o` and `eoc_o` are 0.
- R13: `m_rdata_o` and `s_rdata_o` hold the latest result of each converter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req_i | input | 1 | Requested mode: 0 independent, 1 parallel |
| mode_wr_i | input | 1 | Mode load strobe |
| mode_o | output | 1 | Current mode |
| trig_sel_i | input | 3 | External trigger select |
| ext_trig_i | input | 8 | External trigger lines |
| m_sw_start_i | input | 1 | Primary software start |
| s_sw_start_i | input | 1 | Secondary software start |
| m_len_i | input | 4 | Primary list length minus one |
| s_len_i | input | 4 | Secondary list length minus one |
| m_chans_i | input | 64 | Primary channel list, 4 bits per entry |
| s_chans_i | input | 64 | Secondary channel list, 4 bits per entry |
| m_cv_start_o | output | 1 | Primary converter start |
| m_cv_chan_o | output | 4 | Primary converter channel |
| m_cv_done_i | input | 1 | Primary converter done |
| m_cv_res_i | input | 16 | Primary converter result |
| s_cv_start_o | output | 1 | Secondary converter start |
| s_cv_chan_o | output | 4 | Secondary converter channel |
| s_cv_done_i | input | 1 | Secondary converter done |
| s_cv_res_i | input | 16 | Secondary converter result |
| m_rdata_o | output | 16 | Latest primary result |
| s_rdata_o | output | 16 | Latest secondary result |
| pk_valid_o | output | 1 | Combined word valid |
| pk_ready_i | input | 1 | Consumer ready |
| pk_data_o | output | 32 | Combined word |
| ovr_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Overrun clear |
| ie_m_i | input | 1 | Primary completion enable |
| ie_s_i | input | 1 | Secondary completion enable |
| eoc_o | output | 1 | Sticky completion flag |
| eoc_clr_i | input | 1 | Completion flag clear |

## Verification
In independent mode the lists run once alone and once overlapped, with channels that are the same on both sides. This shows that the two sides do not interact and that only the selected trigger line matters. In parallel mode, uneven latencies in both directions show whether the lockstep gate waits on the slower side. A list with repeated channels in several slots shows whether the same-channel stall works. Holding back ready separates hold-until-taken behaviour from overrun replacement, and enable combinations show how the completion flag is gated in each mode.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_HOLD  = 2'd3
    } sq_state_e;

    typedef enum logic {
        MODE_IND = 1'b0,
        MODE_PAR = 1'b1
    } sync_mode_e;
endpackage

// File: rtl/dcs_seq.sv
module dcs_seq
    import dcs_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int RES_W = 16,
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [$clog2(DEPTH)-1:0] len_i,
    input  logic [DEPTH*CH_W-1:0]   chans_i,
    input  logic                    stall_i,
    input  logic                    go_i,
    output logic                    cv_start_o,
    output logic [CH_W-1:0]         cv_chan_o,
    input  logic                    cv_done_i,
    input  logic [RES_W-1:0]        cv_res_i,
    output logic                    idle_o,
    output logic                    hold_o,
    output logic                    busy_o,
    output logic                    conv_o,
    output logic                    last_o,
    output logic                    seq_end_o,
    output logic [RES_W-1:0]        res_o
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        sq_state_e          st;
        logic [IDX_W-1:0]   idx;
        logic [RES_W-1:0]   res;
    } seq_reg_t;

    seq_reg_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        cv_start_o = 1'b0;
        seq_end_o  = 1'b0;
        case (r_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    r_d.idx = '0;
                    r_d.st  = SQ_ISSUE;
                end
            end
            SQ_ISSUE: begin
                if (!stall_i) begin
                    cv_start_o = 1'b1;
                    r_d.st     = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (cv_done_i) begin
                    r_d.res = cv_res_i;
                    r_d.st  = SQ_HOLD;
                end
            end
            SQ_HOLD: begin
                if (go_i) begin
                    if (r_q.idx == len_i) begin
                        seq_end_o = 1'b1;
                        r_d.st    = SQ_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                        r_d.st  = SQ_ISSUE;
                    end
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SQ_IDLE, idx: '0, res: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cv_chan_o = chans_i[r_q.idx*CH_W +: CH_W];
    assign idle_o    = (r_q.st == SQ_IDLE);
    assign hold_o    = (r_q.st == SQ_HOLD);
    assign busy_o    = (r_q.st == SQ_ISSUE) || (r_q.st == SQ_WAIT);
    assign conv_o    = cv_start_o || (r_q.st == SQ_WAIT);
    assign last_o    = (r_q.idx == len_i);
    assign res_o     = r_q.res;

    // R3: a start is a single-cycle pulse per entry
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start_o |=> !cv_start_o);

    // R3: no new start while a conversion is awaiting its done
    a_r3_wait_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_WAIT && !cv_done_i) |=> !cv_start_o);

    // R13: the result register changes only on a done in the wait state
    a_r13_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.st == SQ_WAIT && cv_done_i) |=> $stable(res_o));
endmodule

// File: rtl/dcs_pack.sv
module dcs_pack #(
    parameter int RES_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [RES_W-1:0]   m_res_i,
    input  logic [RES_W-1:0]   s_res_i,
    input  logic               ready_i,
    input  logic               clr_ovr_i,
    output logic               valid_o,
    output logic [2*RES_W-1:0] data_o,
    output logic               ovr_o
);
    typedef struct packed {
        logic               vld;
        logic [2*RES_W-1:0] dat;
        logic               ovr;
    } pk_reg_t;

    pk_reg_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (p_q.vld && ready_i) begin
            p_d.vld = 1'b0;
        end
        if (clr_ovr_i) begin
            p_d.ovr = 1'b0;
        end
        if (load_i) begin
            p_d.vld = 1'b1;
            p_d.dat = {s_res_i, m_res_i};
            if (p_q.vld && !ready_i) begin
                p_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{vld: 1'b0, dat: '0, ovr: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign valid_o = p_q.vld;
    assign data_o  = p_q.dat;
    assign ovr_o   = p_q.ovr;

    // R6: an untaken word stays offered
    a_r6_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o);

    // R6: an untaken word keeps its data unless replaced
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !load_i) |=> $stable(data_o));

    // R7: replacing an untaken word raises overrun
    a_r7_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && valid_o && !ready_i) |=> ovr_o);

    // R7: overrun is sticky until cleared
    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !clr_ovr_i) |=> ovr_o);
endmodule

// File: rtl/dual_conv_sync.sv
module dual_conv_sync
    import dcs_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int RES_W  = 16,
    parameter int DEPTH  = 16,
    parameter int TRIG_N = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_req_i,
    input  logic                      mode_wr_i,
    output logic                      mode_o,
    input  logic [$clog2(TRIG_N)-1:0] trig_sel_i,
    input  logic [TRIG_N-1:0]         ext_trig_i,
    input  logic                      m_sw_start_i,
    input  logic                      s_sw_start_i,
    input  logic [$clog2(DEPTH)-1:0]  m_len_i,
    input  logic [$clog2(DEPTH)-1:0]  s_len_i,
    input  logic [DEPTH*CH_W-1:0]     m_chans_i,
    input  logic [DEPTH*CH_W-1:0]     s_chans_i,
    output logic                      m_cv_start_o,
    output logic [CH_W-1:0]           m_cv_chan_o,
    input  logic                      m_cv_done_i,
    input  logic [RES_W-1:0]          m_cv_res_i,
    output logic                      s_cv_start_o,
    output logic [CH_W-1:0]           s_cv_chan_o,
    input  logic                      s_cv_done_i,
    input  logic [RES_W-1:0]          s_cv_res_i,
    output logic [RES_W-1:0]          m_rdata_o,
    output logic [RES_W-1:0]          s_rdata_o,
    output logic                      pk_valid_o,
    input  logic                      pk_ready_i,
    output logic [2*RES_W-1:0]        pk_data_o,
    output logic                      ovr_o,
    input  logic                      ovr_clr_i,
    input  logic                      ie_m_i,
    input  logic                      ie_s_i,
    output logic                      eoc_o,
    input  logic                      eoc_clr_i
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        sync_mode_e mode;
        logic       eoc;
    } top_reg_t;

    top_reg_t t_q, t_d;

    logic             par, trig, both_idle, pair_go;
    logic             m_start, s_start, m_go, s_go, s_stall;
    logic [IDX_W-1:0] s_len_eff;
    logic             m_idle, m_hold, m_busy, m_conv, m_last, m_end;
    logic             s_idle, s_hold, s_busy, s_conv, s_last, s_end;
    logic             eoc_set;

    assign par       = (t_q.mode == MODE_PAR);
    assign trig      = ext_trig_i[trig_sel_i];
    assign both_idle = m_idle && s_idle;
    assign pair_go   = m_hold && s_hold;

    always_comb begin
        if (par) begin
            m_start   = trig && both_idle;
            s_start   = trig && both_idle;
            s_len_eff = m_len_i;
            m_go      = pair_go;
            s_go      = pair_go;
            s_stall   = m_busy && (m_cv_chan_o == s_cv_chan_o);
            eoc_set   = pair_go && m_last && s_last && (ie_m_i || ie_s_i);
        end else begin
            m_start   = trig || m_sw_start_i;
            s_start   = s_sw_start_i;
            s_len_eff = s_len_i;
            m_go      = 1'b1;
            s_go      = 1'b1;
            s_stall   = 1'b0;
            eoc_set   = (m_end && ie_m_i) || (s_end && ie_s_i);
        end
    end

    always_comb begin
        t_d = t_q;
        if (mode_wr_i && both_idle) begin
            t_d.mode = sync_mode_e'(mode_req_i);
        end
        if (eoc_clr_i) begin
            t_d.eoc = 1'b0;
        end
        if (eoc_set) begin
            t_d.eoc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{mode: MODE_IND, eoc: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign mode_o = t_q.mode;
    assign eoc_o  = t_q.eoc;

    dcs_seq #(.CH_W(CH_W), .RES_W(RES_W), .DEPTH(DEPTH)) u_mseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (m_start),
        .len_i      (m_len_i),
        .chans_i    (m_chans_i),
        .stall_i    (1'b0),
        .go_i       (m_go),
        .cv_start_o (m_cv_start_o),
        .cv_chan_o  (m_cv_chan_o),
        .cv_done_i  (m_cv_done_i),
        .cv_res_i   (m_cv_res_i),
        .idle_o     (m_idle),
        .hold_o     (m_hold),
        .busy_o     (m_busy),
        .conv_o     (m_conv),
        .last_o     (m_last),
        .seq_end_o  (m_end),
        .res_o      (m_rdata_o)
    );

    dcs_seq #(.CH_W(CH_W), .RES_W(RES_W), .DEPTH(DEPTH)) u_sseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (s_start),
        .len_i      (s_len_eff),
        .chans_i    (s_chans_i),
        .stall_i    (s_stall),
        .go_i       (s_go),
        .cv_start_o (s_cv_start_o),
        .cv_chan_o  (s_cv_chan_o),
        .cv_done_i  (s_cv_done_i),
        .cv_res_i   (s_cv_res_i),
        .idle_o     (s_idle),
        .hold_o     (s_hold),
        .busy_o     (s_busy),
        .conv_o     (s_conv),
        .last_o     (s_last),
        .seq_end_o  (s_end),
        .res_o      (s_rdata_o)
    );

    dcs_pack #(.RES_W(RES_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (par && pair_go),
        .m_res_i   (m_rdata_o),
        .s_res_i   (s_rdata_o),
        .ready_i   (pk_ready_i),
        .clr_ovr_i (ovr_clr_i),
        .valid_o   (pk_valid_o),
        .data_o    (pk_data_o),
        .ovr_o     (ovr_o)
    );

    // R5: never two conversions of one channel at once in parallel mode
    a_r5_no_shared_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (par && m_conv && s_conv) |-> (m_cv_chan_o != s_cv_chan_o));

    // R4: a side that finished its slot waits for the other side
    a_r4_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (par && m_hold && !s_hold) |=> m_hold);

    // R4: the secondary may not run ahead of the primary either
    a_r4_lockstep_s: assert property (@(posedge clk) disable iff (!rst_n)
        (par && s_hold && !m_hold) |=> s_hold);

    // R11: the mode is frozen while any sequencer is busy
    a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !both_idle |=> (mode_o == $past(mode_o)));

    // R10: the completion flag is sticky
    a_r10_eoc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && !eoc_clr_i) |=> eoc_o);
endmodule

// File: tb/sim_dual_conv_sync.sv
module sim_dual_conv_sync;
    localparam int CLK_P = 10;
    localparam int WD_CYC = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_req = 1'b0, mode_wr = 1'b0;
    logic        mode_o;
    logic [2:0]  trig_sel = 3'd0;
    logic [7:0]  ext_trig = 8'd0;
    logic        m_sw = 1'b0, s_sw = 1'b0;
    logic [3:0]  m_len = 4'd0, s_len = 4'd0;
    logic [63:0] m_chans = '0, s_chans = '0;
    logic        m_cv_start, s_cv_start;
    logic [3:0]  m_cv_chan, s_cv_chan;
    logic        m_done = 1'b0, s_done = 1'b0;
    logic [15:0] m_res = '0, s_res = '0;
    logic [15:0] m_rdata, s_rdata;
    logic        pk_valid, pk_ready = 1'b1;
    logic [31:0] pk_data;
    logic        ovr, ovr_clr = 1'b0;
    logic        ie_m = 1'b0, ie_s = 1'b0;
    logic        eoc, eoc_clr = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_conv_sync u0 (
        .clk(clk), .rst_n(rst_n),
        .mode_req_i(mode_req), .mode_wr_i(mode_wr), .mode_o(mode_o),
        .trig_sel_i(trig_sel), .ext_trig_i(ext_trig),
        .m_sw_start_i(m_sw), .s_sw_start_i(s_sw),
        .m_len_i(m_len), .s_len_i(s_len),
        .m_chans_i(m_chans), .s_chans_i(s_chans),
        .m_cv_start_o(m_cv_start), .m_cv_chan_o(m_cv_chan),
        .m_cv_done_i(m_done), .m_cv_res_i(m_res),
        .s_cv_start_o(s_cv_start), .s_cv_chan_o(s_cv_chan),
        .s_cv_done_i(s_done), .s_cv_res_i(s_res),
        .m_rdata_o(m_rdata), .s_rdata_o(s_rdata),
        .pk_valid_o(pk_valid), .pk_ready_i(pk_ready), .pk_data_o(pk_data),
        .ovr_o(ovr), .ovr_clr_i(ovr_clr),
        .ie_m_i(ie_m), .ie_s_i(ie_s),
        .eoc_o(eoc), .eoc_clr_i(eoc_clr)
    );

    int n_chk = 0, n_bad = 0;
    bit fin = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // reference state kept by the bench
    logic [3:0]  m_expq[$], s_expq[$];
    logic [15:0] mq[$], sq[$];
    bit          tb_par = 0, chk_pk = 1;
    bit          m_busy_tb = 0, s_busy_tb = 0;
    logic [3:0]  m_ch = '0, s_ch = '0;
    int          m_cnt = 0, s_cnt = 0, m_lat = 2, s_lat = 3;
    int          m_st = 0, s_st = 0, m_dn = 0, s_dn = 0, pk_seen = 0;
    logic [7:0]  m_seq8 = 8'd0, s_seq8 = 8'd0;
    logic [15:0] last_m = '0, last_s = '0;
    logic        eoc_prev = 1'b0;

    // converter models plus per-clock comparison
    always @(negedge clk) begin
        if (m_done) m_done = 1'b0;
        if (s_done) s_done = 1'b0;
        if (m_busy_tb) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_res = {4'hA, m_seq8, m_ch};
                m_seq8++;
                m_done = 1'b1; m_busy_tb = 0; m_dn++; last_m = m_res;
                if (tb_par) mq.push_back(m_res);
            end
        end
        if (s_busy_tb) begin
            s_cnt--;
            if (s_cnt == 0) begin
                s_res = {4'h5, s_seq8, s_ch};
                s_seq8++;
                s_done = 1'b1; s_busy_tb = 0; s_dn++; last_s = s_res;
                if (tb_par) sq.push_back(s_res);
            end
        end
        if (m_cv_start) begin
            if (m_expq.size() == 0) chk(0, "R1 R2 R4 unexpected primary start", {28'd0, m_cv_chan}, 0);
            else begin
                logic [3:0] e;
                e = m_expq.pop_front();
                chk(m_cv_chan == e, "R3 primary channel order", {28'd0, m_cv_chan}, {28'd0, e});
            end
            chk(!m_busy_tb, "R3 primary start before done", {31'd0, m_busy_tb}, 0);
            if (tb_par) chk(s_dn == m_st, "R4 primary waits for secondary slot", s_dn, m_st);
            m_busy_tb = 1; m_ch = m_cv_chan; m_cnt = m_lat; m_st++;
        end
        if (s_cv_start) begin
            if (s_expq.size() == 0) chk(0, "R1 R4 unexpected secondary start", {28'd0, s_cv_chan}, 0);
            else begin
                logic [3:0] e;
                e = s_expq.pop_front();
                chk(s_cv_chan == e, "R3 secondary channel order", {28'd0, s_cv_chan}, {28'd0, e});
            end
            chk(!s_busy_tb, "R3 secondary start before done", {31'd0, s_busy_tb}, 0);
            if (tb_par) chk(m_st == s_st + 1, "R4 secondary slot matches primary", m_st, s_st + 1);
            s_busy_tb = 1; s_ch = s_cv_chan; s_cnt = s_lat; s_st++;
        end
        if (tb_par && m_busy_tb && s_busy_tb)
            chk(m_ch != s_ch, "R5 shared channel sampled twice", {28'd0, m_ch}, {28'd0, s_ch});
        if (rst_n && chk_pk && pk_valid && pk_ready) begin
            if (mq.size() == 0 || sq.size() == 0) chk(0, "R6 word without results", pk_data, 0);
            else begin
                logic [31:0] w;
                w = {sq.pop_front(), mq.pop_front()};
                chk(pk_data == w, "R6 packed word", pk_data, w);
                pk_seen++;
            end
        end
        if (tb_par && eoc && !eoc_prev)
            chk(m_expq.size() == 0 && s_expq.size() == 0 && !m_busy_tb && !s_busy_tb,
                "R8 flag before final slot", 1, 0);
        eoc_prev = eoc;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input bit sl, input logic [63:0] ch, input int n);
        for (int k = 0; k < n; k++) begin
            if (sl) s_expq.push_back(ch[k*4 +: 4]);
            else    m_expq.push_back(ch[k*4 +: 4]);
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk);
        while (m_expq.size() != 0 || s_expq.size() != 0 || m_busy_tb || s_busy_tb);
        tick(4);
    endtask

    task automatic pulse_trig(input int b);
        ext_trig[b] = 1'b1; tick(1); ext_trig = '0;
    endtask

    function automatic logic [63:0] mk(input logic [3:0] a, b, c, d);
        return {48'd0, d, c, b, a};
    endfunction

    initial begin
        tick(3);
        // R12: reset state
        chk(mode_o == 1'b0, "R12 mode after reset", {31'd0, mode_o}, 0);
        chk(!m_cv_start && !s_cv_start, "R12 no start in reset", {30'd0, m_cv_start, s_cv_start}, 0);
        chk(!pk_valid && !ovr && !eoc, "R12 flags after reset", {29'd0, pk_valid, ovr, eoc}, 0);
        rst_n = 1'b1;
        tick(2);

        // R2: unselected trigger lines do nothing; R1 independent primary run
        trig_sel = 3'd3; ie_m = 0; ie_s = 1;
        m_chans = mk(4'd7, 4'd2, 4'd9, 4'd0); m_len = 4'd2;
        s_chans = mk(4'd2, 4'd7, 4'd9, 4'd4); s_len = 4'd3;
        pulse_trig(1); pulse_trig(6);
        tick(6);
        chk(m_st == 0 && s_st == 0, "R2 unselected line ignored", m_st + s_st, 0);
        push_exp(0, m_chans, 3);
        pulse_trig(3);
        wait_idle();
        chk(m_st == 3 && s_st == 0, "R1 R2 selected trigger runs primary only", m_st * 16 + s_st, 48);
        chk(eoc == 1'b0, "R9 primary end gated by its enable", {31'd0, eoc}, 0);
        chk(m_rdata == last_m, "R13 primary result kept", {16'd0, m_rdata}, {16'd0, last_m});

        // R1: both sides at once on software starts, shared channels allowed
        m_lat = 4; s_lat = 1;
        push_exp(0, m_chans, 3); push_exp(1, s_chans, 4);
        m_sw = 1; s_sw = 1; tick(1); m_sw = 0; s_sw = 0;
        wait_idle();
        chk(m_st == 6 && s_st == 4, "R1 independent overlapped runs", m_st * 16 + s_st, 100);
        chk(eoc == 1'b1, "R9 secondary end sets flag", {31'd0, eoc}, 1);
        chk(s_rdata == last_s, "R13 secondary result kept", {16'd0, s_rdata}, {16'd0, last_s});
        tick(3);
        chk(eoc == 1'b1, "R10 flag sticky", {31'd0, eoc}, 1);
        eoc_clr = 1; tick(1); eoc_clr = 0;
        chk(eoc == 1'b0, "R10 flag cleared", {31'd0, eoc}, 0);

        // R11: mode write during a run is ignored
        m_lat = 6;
        push_exp(0, m_chans, 3);
        m_sw = 1; tick(1); m_sw = 0;
        tick(3);
        mode_req = 1; mode_wr = 1; tick(1); mode_wr = 0;
        tick(2);
        chk(mode_o == 1'b0, "R11 busy mode write ignored", {31'd0, mode_o}, 0);
        wait_idle();
        chk(mode_o == 1'b0, "R11 mode unchanged after run", {31'd0, mode_o}, 0);
        eoc_clr = 1; tick(1); eoc_clr = 0;
        mode_wr = 1; tick(1); mode_wr = 0;
        chk(mode_o == 1'b1, "R11 idle mode write taken", {31'd0, mode_o}, 1);
        tb_par = 1;

        // R4: software starts ignored in parallel mode
        m_sw = 1; s_sw = 1; tick(1); m_sw = 0; s_sw = 0;
        tick(6);
        chk(m_st == 9 && s_st == 4, "R4 software starts ignored", m_st * 16 + s_st, 148);

        // R4 R6 R8: parallel run, secondary slower, secondary length ignored
        m_st = 0; s_st = 0; m_dn = 0; s_dn = 0; pk_seen = 0;
        m_lat = 2; s_lat = 5; ie_m = 0; ie_s = 1;
        m_len = 4'd3; s_len = 4'd0;
        m_chans = mk(4'd1, 4'd2, 4'd3, 4'd4); s_chans = mk(4'd8, 4'd9, 4'd10, 4'd11);
        push_exp(0, m_chans, 4); push_exp(1, s_chans, 4);
        pulse_trig(3);
        wait_idle();
        chk(s_st == 4, "R4 secondary uses primary length", s_st, 4);
        chk(pk_seen == 4, "R6 one word per slot", pk_seen, 4);
        chk(eoc == 1'b1, "R8 flag after final slot", {31'd0, eoc}, 1);
        eoc_clr = 1; tick(1); eoc_clr = 0;

        // R5: shared channels in slots 0, 2, 3; primary slower; enables off
        m_st = 0; s_st = 0; m_dn = 0; s_dn = 0; pk_seen = 0;
        m_lat = 3; s_lat = 1; ie_m = 0; ie_s = 0;
        m_chans = mk(4'd4, 4'd4, 4'd8, 4'd1); s_chans = mk(4'd4, 4'd9, 4'd8, 4'd1);
        push_exp(0, m_chans, 4); push_exp(1, s_chans, 4);
        pulse_trig(3);
        wait_idle();
        chk(pk_seen == 4, "R5 R6 all slots delivered with stalls", pk_seen, 4);
        chk(eoc == 1'b0, "R8 flag gated by both enables off", {31'd0, eoc}, 0);

        // R7: overrun with consumer stalled
        chk_pk = 0; pk_ready = 0; ie_m = 1; ie_s = 0;
        m_st = 0; s_st = 0; m_dn = 0; s_dn = 0;
        m_lat = 2; s_lat = 2; m_len = 4'd1;
        m_chans = mk(4'd3, 4'd5, 4'd0, 4'd0); s_chans = mk(4'd6, 4'd7, 4'd0, 4'd0);
        push_exp(0, m_chans, 2); push_exp(1, s_chans, 2);
        pulse_trig(3);
        wait_idle();
        chk(pk_valid == 1'b1, "R6 word held while not ready", {31'd0, pk_valid}, 1);
        chk(ovr == 1'b1, "R7 overrun set", {31'd0, ovr}, 1);
        chk(pk_data == {last_s, last_m}, "R7 newer word replaces", pk_data, {last_s, last_m});
        chk(eoc == 1'b1, "R8 flag with primary enable only", {31'd0, eoc}, 1);
        tick(3);
        chk(pk_data == {last_s, last_m}, "R6 data stable while held", pk_data, {last_s, last_m});
        chk(ovr == 1'b1, "R7 overrun sticky", {31'd0, ovr}, 1);
        ovr_clr = 1; tick(1); ovr_clr = 0;
        chk(ovr == 1'b0, "R7 overrun cleared", {31'd0, ovr}, 0);
        pk_ready = 1; tick(1); pk_ready = 0;
        chk(pk_valid == 1'b0, "R6 valid drops after take", {31'd0, pk_valid}, 0);

        // R6: single slot held with ready low, no overrun
        mq.delete(); sq.delete();
        m_len = 4'd0;
        push_exp(0, m_chans, 1); push_exp(1, s_chans, 1);
        pulse_trig(3);
        wait_idle();
        chk(pk_valid == 1'b1 && ovr == 1'b0, "R6 R7 single word no overrun", {30'd0, pk_valid, ovr}, 2);
        chk(pk_data == {last_s, last_m}, "R6 word order secondary high", pk_data, {last_s, last_m});
        pk_ready = 1; tick(1);
        chk(pk_valid == 1'b0, "R6 taken", {31'd0, pk_valid}, 0);
        mq.delete(); sq.delete();
        chk_pk = 1;

        chk(m_expq.size() == 0 && s_expq.size() == 0, "R3 all entries issued",
            m_expq.size() + s_expq.size(), 0);
        fin = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL R3 watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule